// File: doc/BRIEF.md
# Indirect Shared-Register Access Bridge

The bridge gives a host a two-register window into a small bank of shared internal registers. The host uses a plain 32-bit register bus with a byte address, a write strobe with write data, and a read strobe with registered read data. One window register is the command word, holding a target offset, an access code and a busy flag. The other is a 32-bit data register. To write, the host first loads the data register and then writes the command word with the write code. To read, the host writes the command word with the read code, waits until busy clears, and then reads the data register.

Each accepted command becomes one transfer on an internal shared-register port. The bridge arbitrates that port against a second internal requester, and the internal requester always has priority. The shared port uses valid/ready. A transfer is offered with `sh_valid` together with its address, direction and write data. It completes in the cycle where `sh_ready` is high, and the responder returns read data in that same cycle. While `sh_ready` stays low, the offered transfer and its fields are held unchanged. Nothing in the window depends on the main processing domain, so it needs no wake-up or access-grant handshake.

Top module: `shrw_bridge`

## Requirements
- R1: The command word is at byte offset 0xEC and the data register is at 0xF4. A read of any other offset returns zero, and a write to any other offset changes neither register. `host_rdata` is updated on the clock edge that samples `host_rd`.
- R2: In the command word, bits [15:0] hold the target offset, bits [29:28] hold the access code and bit 31 is busy. Bits 30 and [27:16] ignore the written value and read back as zero.
- R3: Access code 3 (write) sends the staged data register contents to the target offset with `sh_we` = 1, and leaves the data register holding that value.
- R4: Access code 2 (read) issues a transfer with `sh_we` = 0. The value returned on `sh_rdata` is captured into the data register on the clock edge where the transfer is acknowledged.
- R5: Access codes 0 and 1 start no transfer and leave the data register unchanged. Busy stays 0, and the offset and code are still recorded in the command word.
- R6: Busy reads as 1 from the edge that accepts a read or write command until the edge that completes its transfer.
- R7: While busy, a write to the command word or to the data register is ignored.
- R8: While busy, a host read of the data register returns its previous contents.
- R9: The internal requester always wins the shared port over a pending host transfer. The host transfer stays pending for as long as the internal requester keeps requesting.
- R10: While `sh_valid` is high and `sh_ready` is low, `sh_valid`, `sh_addr`, `sh_we` and `sh_wdata` stay unchanged in the next cycle.
- R11: A synchronous active-low reset clears both window registers, the busy flag and the arbiter lock, including during a pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Registered host read data |
| int_req | input | 1 | Internal requester request, held until acknowledged |
| int_we | input | 1 | Internal requester direction (1 = write) |
| int_addr | input | 16 | Internal requester target offset |
| int_wdata | input | 32 | Internal requester write data |
| int_ack | output | 1 | Internal transfer completes this cycle |
| int_rdata | output | 32 | Read data returned to the internal requester |
| sh_valid | output | 1 | Shared port transfer offered |
| sh_we | output | 1 | Shared port direction (1 = write) |
| sh_addr | output | 16 | Shared port target offset |
| sh_wdata | output | 32 | Shared port write data |
| sh_ready | input | 1 | Responder accepts and completes the offered transfer |
| sh_rdata | input | 32 | Responder read data, valid with sh_ready |

## Verification
Every cycle, the assertions check the following:
- Shared-port fields stay unchanged while a transfer is stalled.
- The internal requester gets the port whenever no transfer is locked.
- Read data is captured on acknowledge, and the staged data is what gets written.
- Busy rises or does not rise according to the access code.
- Busy falls after completion.
- Data writes made while busy are dropped.

Some behaviour is visible only through the bench scenarios at the host bus:
- the read-back layout of the command word, with its zeroed reserved bits;
- the old data register contents seen during a long read;
- the rejection of a second command;
- a host transfer that starves until the internal requester stops;
- a reset in the middle of a transfer.

// File: rtl/shrw_pkg.sv
package shrw_pkg;
  typedef enum logic [1:0] {
    ACC_NOP0  = 2'd0,
    ACC_NOP1  = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_code_e;

  localparam int CODE_LSB = 28;
  localparam int BUSY_BIT = 31;
endpackage

// File: rtl/shrw_window_regs.sv
module shrw_window_regs
  import shrw_pkg::*;
#(
  parameter int HADDR_W  = 8,
  parameter int DATA_W   = 32,
  parameter int OFS_W    = 16,
  parameter logic [HADDR_W-1:0] CTRL_OFS = 8'hEC,
  parameter logic [HADDR_W-1:0] DATA_OFS = 8'hF4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] haddr,
  input  logic               hwr,
  input  logic [DATA_W-1:0]  hwdata,
  input  logic               hrd,
  output logic [DATA_W-1:0]  hrdata,
  input  logic               busy,
  input  logic               cap_en,
  input  logic [DATA_W-1:0]  cap_data,
  output logic               cmd_fire,
  output logic               cmd_we,
  output logic [OFS_W-1:0]   cur_ofs,
  output logic [DATA_W-1:0]  stage_data
);
  logic [OFS_W-1:0]  ofs_q;
  acc_code_e         code_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] ctrl_view;
  logic              ctrl_wr, data_wr;
  acc_code_e         new_code;

  assign ctrl_wr  = hwr && (haddr == CTRL_OFS);
  assign data_wr  = hwr && (haddr == DATA_OFS);
  assign new_code = acc_code_e'(hwdata[CODE_LSB +: 2]);
  assign cmd_fire = ctrl_wr && !busy && new_code[1];
  assign cmd_we   = new_code[0];

  always_comb begin
    ctrl_view                 = '0;
    ctrl_view[OFS_W-1:0]      = ofs_q;
    ctrl_view[CODE_LSB +: 2]  = code_q;
    ctrl_view[BUSY_BIT]       = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      code_q  <= ACC_NOP0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr && !busy) begin
        ofs_q  <= hwdata[OFS_W-1:0];
        code_q <= new_code;
      end
      if (cap_en)
        data_q <= cap_data;
      else if (data_wr && !busy)
        data_q <= hwdata;
      if (hrd) begin
        if (haddr == CTRL_OFS)      rdata_q <= ctrl_view;
        else if (haddr == DATA_OFS) rdata_q <= data_q;
        else                        rdata_q <= '0;
      end
    end
  end

  assign hrdata     = rdata_q;
  assign cur_ofs    = ofs_q;
  assign stage_data = data_q;
endmodule

// File: rtl/shrw_seq.sv
module shrw_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_fire,
  input  logic cmd_we,
  input  logic ack,
  output logic busy,
  output logic op_we,
  output logic cap_en
);
  logic busy_q, we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
    end else if (cmd_fire) begin
      busy_q <= 1'b1;
      we_q   <= cmd_we;
    end else if (ack) begin
      busy_q <= 1'b0;
    end
  end

  assign busy   = busy_q;
  assign op_we  = we_q;
  assign cap_en = ack && !we_q;
endmodule

// File: rtl/shrw_arb.sv
module shrw_arb #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_req,
  input  logic              int_we,
  input  logic [OFS_W-1:0]  int_ofs,
  input  logic [DATA_W-1:0] int_wdata,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [OFS_W-1:0]  h_ofs,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              sh_ready,
  output logic              sh_valid,
  output logic              sh_we,
  output logic [OFS_W-1:0]  sh_addr,
  output logic [DATA_W-1:0] sh_wdata,
  output logic              int_ack,
  output logic              h_ack
);
  logic lock_q, lock_int_q;
  logic gnt_int, gnt_h;

  assign gnt_int  = lock_q ? lock_int_q  : int_req;
  assign gnt_h    = lock_q ? !lock_int_q : (!int_req && h_req);
  assign sh_valid = (gnt_int && int_req) || (gnt_h && h_req);
  assign sh_we    = gnt_int ? int_we    : h_we;
  assign sh_addr  = gnt_int ? int_ofs   : h_ofs;
  assign sh_wdata = gnt_int ? int_wdata : h_wdata;
  assign int_ack  = gnt_int && int_req && sh_ready;
  assign h_ack    = gnt_h && h_req && sh_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_int_q <= 1'b0;
    end else if (sh_valid && !sh_ready) begin
      lock_q     <= 1'b1;
      lock_int_q <= gnt_int;
    end else if (sh_ready) begin
      lock_q     <= 1'b0;
    end
  end
endmodule

// File: rtl/shrw_bridge.sv
module shrw_bridge
  import shrw_pkg::*;
#(
  parameter int HADDR_W = 8,
  parameter int DATA_W  = 32,
  parameter int OFS_W   = 16,
  parameter logic [HADDR_W-1:0] CTRL_OFS = 8'hEC,
  parameter logic [HADDR_W-1:0] DATA_OFS = 8'hF4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_wr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               host_rd,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               int_req,
  input  logic               int_we,
  input  logic [OFS_W-1:0]   int_addr,
  input  logic [DATA_W-1:0]  int_wdata,
  output logic               int_ack,
  output logic [DATA_W-1:0]  int_rdata,
  output logic               sh_valid,
  output logic               sh_we,
  output logic [OFS_W-1:0]   sh_addr,
  output logic [DATA_W-1:0]  sh_wdata,
  input  logic               sh_ready,
  input  logic [DATA_W-1:0]  sh_rdata
);
  logic              busy, op_we, cap_en, cmd_fire, cmd_we, host_ack;
  logic [OFS_W-1:0]  cur_ofs;
  logic [DATA_W-1:0] stage_data;

  shrw_window_regs #(
    .HADDR_W(HADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
    .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .haddr(host_addr), .hwr(host_wr),
    .hwdata(host_wdata), .hrd(host_rd), .hrdata(host_rdata),
    .busy(busy), .cap_en(cap_en), .cap_data(sh_rdata),
    .cmd_fire(cmd_fire), .cmd_we(cmd_we), .cur_ofs(cur_ofs),
    .stage_data(stage_data)
  );

  shrw_seq seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_we(cmd_we),
    .ack(host_ack), .busy(busy), .op_we(op_we), .cap_en(cap_en)
  );

  shrw_arb #(.DATA_W(DATA_W), .OFS_W(OFS_W)) arb_i (
    .clk(clk), .rst_n(rst_n),
    .int_req(int_req), .int_we(int_we), .int_ofs(int_addr), .int_wdata(int_wdata),
    .h_req(busy), .h_we(op_we), .h_ofs(cur_ofs), .h_wdata(stage_data),
    .sh_ready(sh_ready), .sh_valid(sh_valid), .sh_we(sh_we),
    .sh_addr(sh_addr), .sh_wdata(sh_wdata), .int_ack(int_ack), .h_ack(host_ack)
  );

  assign int_rdata = sh_rdata;
endmodule

// File: rtl/shrw_bridge_chk.sv
module shrw_bridge_chk #(
  parameter int HADDR_W = 8,
  parameter int DATA_W  = 32,
  parameter int OFS_W   = 16,
  parameter logic [HADDR_W-1:0] CTRL_OFS = 8'hEC,
  parameter logic [HADDR_W-1:0] DATA_OFS = 8'hF4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HADDR_W-1:0] host_addr,
  input logic               host_wr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic               int_req,
  input logic [OFS_W-1:0]   int_addr,
  input logic               sh_valid,
  input logic               sh_we,
  input logic [OFS_W-1:0]   sh_addr,
  input logic [DATA_W-1:0]  sh_wdata,
  input logic               sh_ready,
  input logic [DATA_W-1:0]  sh_rdata,
  input logic               busy,
  input logic               host_ack,
  input logic [DATA_W-1:0]  data_q
);
  logic stall_q;
  logic ctrl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= sh_valid && !sh_ready;
  end

  assign ctrl_wr = host_wr && (host_addr == CTRL_OFS);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && !sh_ready) |=> (sh_valid && $stable(sh_addr) && $stable(sh_we) && $stable(sh_wdata)));

  a_r9_internal_first: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !stall_q) |-> (sh_valid && !host_ack && sh_addr == int_addr));

  a_r4_capture_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !sh_we) |=> (data_q == $past(sh_rdata)));

  a_r3_stage_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && sh_we) |-> (sh_wdata == data_q));

  a_r6_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy && host_wdata[29]) |=> busy);

  a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !busy);

  a_r5_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy && !host_wdata[29]) |=> !busy);

  a_r7_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !host_ack && host_wr && host_addr == DATA_OFS) |=> $stable(data_q));
endmodule

bind shrw_bridge shrw_bridge_chk #(
  .HADDR_W(HADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
  .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .int_req(int_req), .int_addr(int_addr),
  .sh_valid(sh_valid), .sh_we(sh_we), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
  .sh_ready(sh_ready), .sh_rdata(sh_rdata), .busy(busy), .host_ack(host_ack),
  .data_q(stage_data)
);

// File: tb/shrw_bridge_tb_top.sv
`timescale 1ns/1ps
module shrw_bridge_tb_top;
  localparam logic [7:0] CTRL = 8'hEC;
  localparam logic [7:0] DATA = 8'hF4;

  typedef struct packed {
    logic [1:0]  code;
    logic [15:0] ofs;
    logic [31:0] wd;
    logic [7:0]  lat;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 16'h0001, 32'hA5A5_0001, 8'd0, 32'hA5A5_0001},
    '{2'd2, 16'h0001, 32'h0,         8'd1, 32'hA5A5_0001},
    '{2'd3, 16'h01DC, 32'h1234_5678, 8'd2, 32'h1234_5678},
    '{2'd2, 16'h0001, 32'h0,         8'd3, 32'hA5A5_0001},
    '{2'd2, 16'h01DC, 32'h0,         8'd0, 32'h1234_5678},
    '{2'd3, 16'h0007, 32'hDEAD_BEEF, 8'd1, 32'hDEAD_BEEF},
    '{2'd2, 16'h0007, 32'h0,         8'd2, 32'hDEAD_BEEF},
    '{2'd2, 16'h0003, 32'h0,         8'd0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        int_req = 1'b0, int_we = 1'b0, int_ack;
  logic [15:0] int_addr = '0;
  logic [31:0] int_wdata = '0, int_rdata;
  logic        sh_valid, sh_we, sh_ready;
  logic [15:0] sh_addr;
  logic [31:0] sh_wdata, sh_rdata;

  int tests = 0, fails = 0;
  int lat = 0, wcnt = 0, txn_cnt = 0, hold_err = 0, cycles = 0;
  logic [31:0] mem [16];
  logic        pv_stall = 1'b0;
  logic [15:0] pv_addr;
  logic        pv_we;
  logic [31:0] pv_wd;

  always #2.5 clk = ~clk;

  shrw_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_ack(int_ack), .int_rdata(int_rdata), .sh_valid(sh_valid), .sh_we(sh_we),
    .sh_addr(sh_addr), .sh_wdata(sh_wdata), .sh_ready(sh_ready), .sh_rdata(sh_rdata)
  );

  assign sh_ready = sh_valid && (wcnt >= lat);
  assign sh_rdata = mem[sh_addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
      wcnt <= 0;
      pv_stall <= 1'b0;
    end else begin
      if (pv_stall && !(sh_valid && sh_addr == pv_addr && sh_we == pv_we && sh_wdata == pv_wd))
        hold_err <= hold_err + 1;
      pv_stall <= sh_valid && !sh_ready;
      pv_addr  <= sh_addr;
      pv_we    <= sh_we;
      pv_wd    <= sh_wdata;
      if (sh_valid && sh_ready) begin
        wcnt <= 0;
        txn_cnt <= txn_cnt + 1;
        if (sh_we) mem[sh_addr[3:0]] <= sh_wdata;
      end else if (sh_valid) begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary_and_end();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      hread(CTRL, v);
      if (!v[31]) return;
    end
    check(tag, v, {1'b0, v[30:0]});
  endtask

  function automatic logic [31:0] cmd(input logic [1:0] c, input logic [15:0] o);
    return {2'b00, c, 12'h000, o};
  endfunction

  initial begin
    logic [31:0] v;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hread(CTRL, v); check("R11 reset command word", v, 32'h0);
    hread(DATA, v); check("R11 reset data register", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      lat = int'(VECS[i].lat);
      if (VECS[i].code == 2'd3) hwrite(DATA, VECS[i].wd);
      hwrite(CTRL, cmd(VECS[i].code, VECS[i].ofs));
      wait_idle("R6 busy clears");
      hread(DATA, v);
      check(VECS[i].code == 2'd3 ? "R3 write staged data" : "R4 read captured", v, VECS[i].exp);
      hread(CTRL, v);
      check("R2 command readback", v, cmd(VECS[i].code, VECS[i].ofs));
    end

    lat = 0;
    hwrite(8'h10, 32'hFFFF_FFFF);
    hread(8'h10, v); check("R1 unmapped read zero", v, 32'h0);
    hread(DATA, v);  check("R1 unmapped write no effect", v, 32'h0);

    hwrite(DATA, 32'h0000_5555);
    t0 = txn_cnt;
    hwrite(CTRL, cmd(2'd1, 16'h0002));
    hread(CTRL, v);  check("R5 code 1 not busy", v, cmd(2'd1, 16'h0002));
    hread(DATA, v);  check("R5 data unchanged", v, 32'h0000_5555);
    check("R5 no transfer", txn_cnt - t0, 0);
    hwrite(CTRL, 32'h4FFF_0003);
    hread(CTRL, v);  check("R2 reserved bits zero", v, 32'h0000_0003);
    check("R5 code 0 no transfer", txn_cnt - t0, 0);

    lat = 20;
    hwrite(DATA, 32'h0000_1111);
    t0 = txn_cnt;
    hwrite(CTRL, cmd(2'd2, 16'h01DC));
    hread(CTRL, v);  check("R6 busy set", v, 32'h8000_0000 | cmd(2'd2, 16'h01DC));
    hread(DATA, v);  check("R8 old data while busy", v, 32'h0000_1111);
    hwrite(DATA, 32'h0000_9999);
    hwrite(CTRL, cmd(2'd3, 16'h0004));
    wait_idle("R6 busy clears long");
    hread(DATA, v);  check("R7 R4 data after busy writes", v, 32'h1234_5678);
    hread(CTRL, v);  check("R7 second command ignored", v, cmd(2'd2, 16'h01DC));
    check("R7 single transfer", txn_cnt - t0, 1);

    lat = 0;
    hwrite(DATA, 32'h0000_ABCD);
    @(negedge clk);
    int_req = 1'b1; int_we = 1'b1; int_addr = 16'h0009; int_wdata = 32'h77;
    hwrite(CTRL, cmd(2'd3, 16'h0006));
    repeat (10) @(negedge clk);
    hread(CTRL, v);  check("R9 host waits for internal", v[31], 1'b1);
    int_req = 1'b0;
    wait_idle("R9 host completes");
    hwrite(CTRL, cmd(2'd2, 16'h0006));
    wait_idle("R9 readback idle");
    hread(DATA, v);  check("R9 host write landed", v, 32'h0000_ABCD);
    hwrite(CTRL, cmd(2'd2, 16'h0009));
    wait_idle("R9 internal readback idle");
    hread(DATA, v);  check("R9 internal writes served", v, 32'h77);

    check("R10 stalled fields held", hold_err, 0);

    lat = 50;
    hwrite(DATA, 32'h0000_0042);
    hwrite(CTRL, cmd(2'd2, 16'h0001));
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    hread(CTRL, v);  check("R11 reset mid transfer command", v, 32'h0);
    hread(DATA, v);  check("R11 reset mid transfer data", v, 32'h0);
    check("R11 no offer after reset", {31'b0, sh_valid}, 32'h0);

    summary_and_end();
  end
endmodule